// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol engine of a byte-wide serial memory that sits on a two-wire bus. It takes SCL and SDA, which have already been brought into the system clock domain. It detects START and STOP conditions and shifts bits in on the rising edges of SCL. It answers with an open-drain SDA enable that it changes only while SCL is low. An internal synchronous RAM holds the data. The engine keeps the byte address counter and runs these operations:

- byte and page writes, where the page wraps within an aligned row;
- current-address reads;
- random reads, made of an address-only write followed by a repeated START;
- sequential reads that carry on through the top address back to zero.

A write-protect input lets select and address bytes through but refuses data. A busy flag from the external programming controller makes the engine stay silent on the bus. The engine raises a one-cycle request to that controller when a write transfer ends correctly.

The array depth is set by `ADDR_W`; the default is 11 bits, or 2048 bytes. The master always sends 16 address bits, most significant byte first, and the engine drops every bit above `ADDR_W`. The page size is set by `PAGE_W`; the default is 6 bits, or 64 bytes. The RAM is not reset.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset, sda_oe_o and pgm_req_o are low. The bus is released and no program request is pending.
- R2: The engine acknowledges a select byte only when its upper seven bits are 1010000, sent MSB first. Bit 0 is the direction bit: 0 means write, 1 means read. After any other select byte, the engine does not acknowledge and ignores the bus until the next START.
- R3: A write select is followed by two address bytes, high byte first. Only the low ADDR_W bits of the 16-bit address are used. Each data byte that follows is acknowledged and stored at the address counter.
- R4: During a write, the counter advances only in its low PAGE_W bits. A page write that passes the end of a page wraps to the first byte of the same page.
- R5: While wc_i is high, the select and address bytes are still acknowledged. Data bytes are not acknowledged and the memory is not changed.
- R6: A read select without an address returns the byte at the address counter. The counter then increments.
- R7: An address-only write followed by a repeated START with a read select returns the byte at the loaded address.
- R8: When the master acknowledges a read byte, the next byte follows. The counter wraps from the last address to 0.
- R9: When the master does not acknowledge a read byte, the engine releases SDA and ignores the bus until the next START.
- R10: While busy_i is high, a matching select byte is not acknowledged.
- R11: pgm_req_o pulses for exactly one cycle on a STOP that follows at least one stored data byte. The STOP must come in the first bit slot after that byte's acknowledge. A STOP after a read, or after address bytes only, gives no pulse.
- R12: A START at any bit position aborts the transfer in progress and begins reception of a new select byte.
- R13: The engine turns on its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (bus level) |
| wc_i | input | 1 | Write protect, high refuses data bytes; low when undriven |
| busy_i | input | 1 | Program cycle in progress |
| sda_oe_o | output | 1 | Pull SDA low when high |
| pgm_req_o | output | 1 | One-cycle request to start a program cycle |

## Verification
The assertions take some things as given about the inputs:

- Each SCL level lasts at least two system clocks.
- The master changes SDA only while SCL is low, except to make a START or STOP.
- The master never issues a START while the engine is pulling SDA low.
- busy_i rises only after a STOP and falls before the next transfer.

The bench master holds each SCL phase for six clocks. It moves SDA only in the low phase. It raises busy only from its program-controller model after a request, and waits for busy to clear before the next transfer.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } eep_state_e;

  localparam logic [6:0] SEL_CODE = 7'b1010000;
endpackage

// File: rtl/eep_bus_mon.sv
module eep_bus_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges with SCL held high are bus conditions
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/eep_ram.sv
module eep_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int AW = 11,
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          sda_i,
  input  logic          wc_i,
  input  logic          busy_i,
  input  logic [7:0]    rdata_i,
  output logic          sda_oe_o,
  output logic          pgm_req_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] raddr_o
);
  localparam int HW = AW - 8;

  eep_state_e    state_q;
  logic [3:0]    cnt_q;
  logic [7:0]    shr_q;
  logic [7:0]    txr_q;
  logic [HW-1:0] ahi_q;
  logic [AW-1:0] addr_q;
  logic          oe_q, pgm_q, rd_q, mack_q, wrote_q;

  logic          rx_state, byte_done, dev_match;
  logic [AW-1:0] addr_pg_inc;

  assign rx_state  = (state_q == ST_DEV) || (state_q == ST_AHI) ||
                     (state_q == ST_ALO) || (state_q == ST_WDAT);
  assign byte_done = rx_state && scl_fall_i && (cnt_q == 4'd8);
  assign dev_match = (shr_q[7:1] == SEL_CODE) && !busy_i;
  assign addr_pg_inc = {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};

  assign we_o      = byte_done && (state_q == ST_WDAT) && !wc_i;
  assign waddr_o   = addr_q;
  assign wdata_o   = shr_q;
  assign raddr_o   = addr_q;
  assign sda_oe_o  = oe_q;
  assign pgm_req_o = pgm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shr_q   <= '0;
      txr_q   <= '0;
      ahi_q   <= '0;
      addr_q  <= '0;
      oe_q    <= 1'b0;
      pgm_q   <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      pgm_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        wrote_q <= 1'b0;
      end else if (stop_i) begin
        // program only on a STOP in the bit slot right after a data ack
        if (state_q == ST_WDAT && wrote_q && cnt_q == 4'd1) pgm_q <= 1'b1;
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        wrote_q <= 1'b0;
      end else if (rx_state) begin
        if (scl_rise_i && cnt_q < 4'd8) begin
          shr_q <= {shr_q[6:0], sda_i};
          cnt_q <= cnt_q + 4'd1;
        end else if (byte_done) begin
          cnt_q <= 4'd9;
          case (state_q)
            ST_DEV: begin
              if (dev_match) begin
                oe_q <= 1'b1;
                rd_q <= shr_q[0];
              end else begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
              end
            end
            ST_AHI: begin
              ahi_q <= shr_q[HW-1:0];
              oe_q  <= 1'b1;
            end
            ST_ALO: begin
              addr_q <= {ahi_q, shr_q};
              oe_q   <= 1'b1;
            end
            default: begin
              if (!wc_i) begin
                oe_q    <= 1'b1;
                addr_q  <= addr_pg_inc;
                wrote_q <= 1'b1;
              end
            end
          endcase
        end else if (scl_fall_i && cnt_q == 4'd9) begin
          oe_q  <= 1'b0;
          cnt_q <= '0;
          case (state_q)
            ST_DEV: begin
              if (rd_q) begin
                state_q <= ST_RDAT;
                txr_q   <= rdata_i;
                oe_q    <= ~rdata_i[7];
              end else begin
                state_q <= ST_AHI;
              end
            end
            ST_AHI:  state_q <= ST_ALO;
            ST_ALO:  state_q <= ST_WDAT;
            default: state_q <= state_q;
          endcase
        end
      end else if (state_q == ST_RDAT) begin
        if (scl_fall_i && cnt_q < 4'd7) begin
          txr_q <= {txr_q[6:0], 1'b0};
          oe_q  <= ~txr_q[6];
          cnt_q <= cnt_q + 4'd1;
        end else if (scl_fall_i && cnt_q == 4'd7) begin
          oe_q   <= 1'b0;
          cnt_q  <= 4'd8;
          addr_q <= addr_q + AW'(1);
        end else if (scl_rise_i && cnt_q == 4'd8) begin
          mack_q <= ~sda_i;
        end else if (scl_fall_i && cnt_q == 4'd8) begin
          cnt_q <= '0;
          if (mack_q) begin
            txr_q <= rdata_i;
            oe_q  <= ~rdata_i[7];
          end else begin
            state_q <= ST_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  input  logic busy_i,
  output logic sda_oe_o,
  output logic pgm_req_o
);
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [7:0]        ram_wdata, ram_rdata;

  eep_bus_mon u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  eep_ctrl #(.AW(ADDR_W), .PW(PAGE_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_evt),
    .stop_i     (stop_evt),
    .sda_i      (sda_i),
    .wc_i       (wc_i),
    .busy_i     (busy_i),
    .rdata_i    (ram_rdata),
    .sda_oe_o   (sda_oe_o),
    .pgm_req_o  (pgm_req_o),
    .we_o       (ram_we),
    .waddr_o    (ram_waddr),
    .wdata_o    (ram_wdata),
    .raddr_o    (ram_raddr)
  );

  eep_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wc_i,
  input logic busy_i,
  input logic sda_oe_o,
  input logic pgm_req_o,
  input logic stop_evt,
  input logic ram_we
);
  a_r1_quiet_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> (!sda_oe_o && !pgm_req_o));

  a_r13_drive_on_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  a_r11_pgm_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_o |=> !pgm_req_o);

  a_r11_pgm_from_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_o |-> $past(stop_evt));

  a_r5_no_write_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> !wc_i);

  a_r10_silent_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> !$rose(sda_oe_o));
endmodule

bind eep_i2c_slave eep_i2c_slave_chk u_chk (.*);

// File: tb/eep_i2c_slave_tb.sv
module eep_i2c_slave_tb;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wc = 1'b0, busy_force = 1'b0;
  logic sda_oe, pgm_req, sda_bus, busy;
  int   busy_cnt = 0, pgm_cnt = 0, r13_bad = 0;
  logic oe_d = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] ref_mem [DEPTH];
  logic       ref_v   [DEPTH];
  logic [7:0] wbuf    [8];
  logic [AW-1:0] exp_ptr = '0;

  always #2 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;
  assign busy = busy_force | (busy_cnt != 0);

  eep_i2c_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .wc_i(wc), .busy_i(busy), .sda_oe_o(sda_oe), .pgm_req_o(pgm_req)
  );

  // program controller model and R13 drive monitor
  always @(negedge clk) begin
    if (pgm_req) begin
      pgm_cnt++;
      busy_cnt = 40;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
    if (rst_n && sda_oe && !oe_d && m_scl) r13_bad++;
    oe_d = sda_oe;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b0; tick(HP);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_sda = 1'b1; tick(HP);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(HP);
    m_scl = 1'b1; tick(HP / 2);
    ack = ~sda_bus;
    tick(HP / 2);
    m_scl = 1'b0; tick(1);
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    m_sda = 1'b1;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      m_scl = 1'b1; tick(HP / 2);
      d = {d[6:0], sda_bus};
      tick(HP / 2);
      m_scl = 1'b0; tick(1);
    end
    m_sda = ~mack; tick(HP);
    m_scl = 1'b1; tick(HP);
    m_scl = 1'b0; tick(1);
    m_sda = 1'b1;
  endtask

  task automatic start_write(input logic [15:0] a, input string req);
    logic k;
    bus_start();
    send_byte(8'hA0, k);   chk(req, k, 1);
    send_byte(a[15:8], k); chk(req, k, 1);
    send_byte(a[7:0], k);  chk(req, k, 1);
    exp_ptr = a[AW-1:0];
  endtask

  task automatic pg_write(input logic [15:0] a, input int n, input string req);
    logic k;
    logic [AW-1:0] idx;
    start_write(a, req);
    for (int j = 0; j < n; j++) begin
      send_byte(wbuf[j], k);
      chk(req, k, !wc);
      idx = {a[AW-1:6], 6'(a[5:0] + 6'(j))};
      if (!wc) begin
        ref_mem[idx] = wbuf[j];
        ref_v[idx]   = 1'b1;
        exp_ptr      = {a[AW-1:6], 6'(a[5:0] + 6'(j + 1))};
      end
    end
    bus_stop();
    tick(60);
  endtask

  task automatic rd_from(input logic [15:0] a, input int n, input string req);
    logic k;
    logic [7:0] d;
    logic [AW-1:0] idx;
    start_write(a, req);
    bus_start();
    send_byte(8'hA1, k); chk(req, k, 1);
    for (int j = 0; j < n; j++) begin
      recv_byte(d, j < n - 1);
      idx = AW'(a[AW-1:0] + AW'(j));
      if (ref_v[idx]) chk(req, d, ref_mem[idx]);
    end
    exp_ptr = AW'(a[AW-1:0] + AW'(n));
    bus_stop();
    tick(HP);
  endtask

  task automatic cur_read(input string req);
    logic k;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA1, k); chk(req, k, 1);
    recv_byte(d, 1'b0);
    chk(req, d, ref_mem[exp_ptr]);
    exp_ptr = exp_ptr + AW'(1);
    bus_stop();
    tick(HP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    logic k;
    logic [7:0] d;
    int pc;
    logic [15:0] ra;
    int rn;
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) ref_v[i] = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 oe", sda_oe, 0);
    chk("R1 pgm", pgm_req, 0);

    // R3 byte write with ignored upper address bits, then R7 random read
    wbuf[0] = 8'h5A;
    pg_write(16'hC123, 1, "R3");
    chk("R11 pulse after write", pgm_cnt, 1);
    rd_from(16'h0123, 1, "R7");
    chk("R11 none after read", pgm_cnt, 1);
    cur_read("R6");

    // R4 page wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    pg_write(16'h007E, 3, "R4");
    rd_from(16'h0040, 1, "R4");
    chk("R4 wrapped", ref_mem[11'h040], 8'h33);
    rd_from(16'h007E, 2, "R4");

    // R5 write protect
    pc = pgm_cnt;
    wc = 1'b1;
    wbuf[0] = 8'hA5;
    pg_write(16'h0123, 1, "R5");
    wc = 1'b0;
    rd_from(16'h0123, 1, "R5");
    chk("R11 none when protected", pgm_cnt, pc);

    // R11 address-only write sets counter, no program request
    pc = pgm_cnt;
    start_write(16'h007E, "R11");
    bus_stop(); tick(20);
    chk("R11 none after address only", pgm_cnt, pc);
    cur_read("R6 after dummy write");

    // R8 rollover
    wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
    pg_write(16'h07FE, 2, "R8");
    wbuf[0] = 8'h01; wbuf[1] = 8'h02;
    pg_write(16'h0000, 2, "R8");
    rd_from(16'h07FE, 4, "R8");
    cur_read("R8 counter past rollover");

    // R2 wrong select code, then bytes without START are ignored
    bus_start();
    send_byte(8'hA2, k); chk("R2 wrong code", k, 0);
    send_byte(8'hA0, k); chk("R2 ignored until START", k, 0);
    bus_stop(); tick(HP);

    // R9 master nack, then ignored until START
    bus_start();
    send_byte(8'hA1, k); chk("R9", k, 1);
    recv_byte(d, 1'b0);
    exp_ptr = exp_ptr + AW'(1);
    send_byte(8'hA0, k); chk("R9 ignored after nack", k, 0);
    bus_stop(); tick(HP);

    // R10 busy
    busy_force = 1'b1;
    bus_start();
    send_byte(8'hA0, k); chk("R10 busy nack", k, 0);
    bus_stop(); tick(HP);
    busy_force = 1'b0; tick(2);
    bus_start();
    send_byte(8'hA0, k); chk("R10 ack after busy", k, 1);
    bus_stop(); tick(HP);

    // R12 START in mid byte
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    cur_read("R12");

    // constrained random page writes and read-back
    for (int it = 0; it < 6; it++) begin
      ra = 16'($urandom);
      rn = 1 + int'($urandom % 6);
      for (int j = 0; j < 8; j++) wbuf[j] = 8'($urandom);
      pg_write(ra, rn, "R3 random");
      rd_from(ra, rn, "R8 random");
    end

    chk("R13 drive only on SCL low", r13_bad, 0);
    summary();
  end
endmodule